// File: doc/BRIEF.md
# Four-Channel PCM Highway Slot Interface

This block joins four voice channels to one serial PCM highway. It runs on the highway bit clock. A single frame sync marks the start of the frame for both directions. The block does not need to be told the highway speed. It counts bit clocks between frame syncs and works out which of five standard rates is present. It only starts to drive the highway once that count has been the same for two measured frames in a row.

Each channel has its own transmit slot and its own receive slot, an enable, and a sample width. The width is either 8 bits (one slot) or 16 bits (two adjacent slots). The transmit side shifts out each enabled channel's sample in its slot and raises an output enable for those bits only. A pad outside this block turns a low enable into high impedance. The receive side gathers each enabled channel's bits and presents the finished word with a one-clock valid strobe. A global bit offset moves all slot boundaries later by that many bit clocks.

Top module: `pcm_slot_if`

## Requirements
- R1: While reset is held, `txOe`, `txData`, `rxValid`, `rateLocked` and `rateError` are all 0.
- R2: The frame begins at the first rising `bclk` edge at which `fsync` is high after being low. Frame bit 0 is driven from that edge. Transmit bits change on rising edges and receive bits are sampled on falling edges.
- R3: A measured frame length of 192, 193, 256, 512 or 1024 clocks gives `rateCode` 0, 1, 2, 3 or 4. `rateLocked` rises at the frame start that ends the second of two consecutive equal, supported measurements. This is the third frame sync after reset. Transmission begins with the frame that starts at that edge.
- R4: A measured length that differs from the previous one clears `rateLocked`. An unsupported length also sets `rateError`. Running 2047 clocks after a frame sync without the next frame sync sets `rateError` and clears the lock. Nothing is driven while the block is unlocked or in error.
- R5: For an 8-bit channel with transmit slot s, effective bits 8s to 8s+7 carry bits 7 down to 0 of its sample word, with `txOe` high.
- R6: For a 16-bit channel, slots s and s+1 carry bits 15 down to 0 of the sample word, most significant bit first.
- R7: The effective bit position is the frame bit position minus `bitOffset`. The bits before the offset continue the previous frame's count.
- R8: After the last bit of a channel's receive slot (slot s+1 when 16-bit), `rxSamples` for that channel holds the received bits, first bit as most significant. In 8-bit mode the upper byte is zero. `rxValid` for that channel pulses for exactly one clock.
- R9: A channel whose `chEnable` bit is 0 never drives the highway and never raises its `rxValid`.
- R10: When several enabled channels claim the same transmit bit, the lowest-numbered channel is sent.
- R11: Transmit sample words are captured at the frame start. A change made during a frame is first sent in the following frame.
- R12: Whenever `txOe` is 0, `txData` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Highway bit clock |
| rstN | input | 1 | Asynchronous reset, active low |
| fsync | input | 1 | 8 kHz frame sync shared by both directions |
| rxData | input | 1 | Serial receive data from the highway |
| bitOffset | input | OFFW (3) | Global slot-boundary delay in bit clocks |
| txSlots | input | NCH*SLOTW (28) | Transmit slot of each channel, channel 0 in the low bits |
| rxSlots | input | NCH*SLOTW (28) | Receive slot of each channel |
| wideMode | input | NCH (4) | 1 selects 16-bit samples for the channel |
| chEnable | input | NCH (4) | 1 powers the channel up |
| txSamples | input | NCH*16 (64) | Transmit sample words, channel 0 in the low bits |
| txData | output | 1 | Serial transmit data |
| txOe | output | 1 | High while a channel drives `txData` |
| rxSamples | output | NCH*16 (64) | Received words per channel |
| rxValid | output | NCH (4) | One-clock strobe per channel when its word completes |
| rateCode | output | 3 | Detected rate code, meaningful while locked |
| rateLocked | output | 1 | Rate measurement stable and accepted |
| rateError | output | 1 | Unsupported frame length or missing frame sync |

## Verification
The hardest states to reach are the lock transitions and the frame-sync starvation timeout. The bench walks through all five supported frame lengths one after another. It checks that each change first drops the lock and then regains it with the new code. It then feeds a 300-clock frame, and later withholds the frame sync for over 2047 clocks, to force the error path. The wrap of the slot count across the frame boundary under a nonzero offset is covered by re-running the full slot map with an offset of three bits.

// File: rtl/pcm_slot_pkg.sv
package pcm_slot_pkg;

  localparam int SLOT_BITS = 8;
  localparam int SLOT_LOG  = 3;
  localparam int WIDE_BITS = 16;

  localparam logic [2:0] RATE_1536 = 3'd0;
  localparam logic [2:0] RATE_1544 = 3'd1;
  localparam logic [2:0] RATE_2048 = 3'd2;
  localparam logic [2:0] RATE_4096 = 3'd3;
  localparam logic [2:0] RATE_8192 = 3'd4;

  // strobes from the frame control to the slot datapath
  typedef struct packed {
    logic frameStart;
    logic drive;
    logic rxArm;
  } ctl_t;

  // {supported, code} for a frame whose last bit position is lastPos
  function automatic logic [3:0] decodeLen(input int unsigned lastPos);
    case (lastPos + 1)
      192:     return {1'b1, RATE_1536};
      193:     return {1'b1, RATE_1544};
      256:     return {1'b1, RATE_2048};
      512:     return {1'b1, RATE_4096};
      1024:    return {1'b1, RATE_8192};
      default: return 4'b0000;
    endcase
  endfunction

endpackage

// File: rtl/pcm_slot_ctrl.sv
module pcm_slot_ctrl
  import pcm_slot_pkg::*;
#(
  parameter int CNTW = 11,
  parameter int OFFW = 3
) (
  input  logic            bclk,
  input  logic            rstN,
  input  logic            fsync,
  input  logic [OFFW-1:0] bitOffset,
  output ctl_t            ctl,
  output logic [CNTW-1:0] effNext,
  output logic [CNTW-1:0] effCur,
  output logic [2:0]      rateCode,
  output logic            rateLocked,
  output logic            rateError
);

  localparam logic [CNTW-1:0] POS_MAX = '1;
  localparam logic [CNTW-1:0] POS_TOP = POS_MAX - 1'b1;

  logic            fsPrev;
  logic            fsStart;
  logic [CNTW-1:0] pos, posNext;
  logic [CNTW-1:0] eff;
  logic            seenQ, seenD;
  logic            prevOkQ, prevOkD;
  logic [CNTW-1:0] prevPosQ, prevPosD;
  logic            lockQ, lockD;
  logic            errQ, errD;
  logic [2:0]      codeQ, codeD;
  logic [3:0]      lenDec;

  assign fsStart = fsync & ~fsPrev;
  assign posNext = fsStart ? '0 : ((pos == POS_MAX) ? POS_MAX : pos + 1'b1);
  assign effNext = (posNext == CNTW'(bitOffset)) ? '0
                 : ((eff == POS_MAX) ? POS_MAX : eff + 1'b1);
  assign lenDec  = decodeLen(int'(pos));

  always_comb begin
    seenD    = seenQ;
    prevOkD  = prevOkQ;
    prevPosD = prevPosQ;
    lockD    = lockQ;
    errD     = errQ;
    codeD    = codeQ;
    if (fsStart) begin
      seenD = 1'b1;
      if (seenQ) begin
        errD     = ~lenDec[3];
        lockD    = lenDec[3] & prevOkQ & (pos == prevPosQ);
        prevPosD = pos;
        prevOkD  = lenDec[3];
        if (lockD) codeD = lenDec[2:0];
      end
    end else if (seenQ && pos == POS_TOP) begin
      errD    = 1'b1;
      lockD   = 1'b0;
      prevOkD = 1'b0;
    end
  end

  always_ff @(posedge bclk or negedge rstN) begin
    if (!rstN) begin
      fsPrev   <= 1'b0;
      pos      <= POS_MAX;
      eff      <= POS_MAX;
      seenQ    <= 1'b0;
      prevOkQ  <= 1'b0;
      prevPosQ <= '0;
      lockQ    <= 1'b0;
      errQ     <= 1'b0;
      codeQ    <= RATE_1536;
    end else begin
      fsPrev   <= fsync;
      pos      <= posNext;
      eff      <= effNext;
      seenQ    <= seenD;
      prevOkQ  <= prevOkD;
      prevPosQ <= prevPosD;
      lockQ    <= lockD;
      errQ     <= errD;
      codeQ    <= codeD;
    end
  end

  assign ctl.frameStart = fsStart;
  assign ctl.drive      = lockD & ~errD;
  assign ctl.rxArm      = lockQ & ~errQ;
  assign effCur         = eff;
  assign rateCode       = codeQ;
  assign rateLocked     = lockQ;
  assign rateError      = errQ;

  assert_start_zero_R2: assert property (@(posedge bclk) disable iff (!rstN)
    fsStart |=> (pos == '0));

  assert_lock_on_sync_R3: assert property (@(posedge bclk) disable iff (!rstN)
    $rose(lockQ) |-> $past(fsStart));

  assert_error_unlocked_R4: assert property (@(posedge bclk) disable iff (!rstN)
    errQ |-> !lockQ);

endmodule

// File: rtl/pcm_slot_dp.sv
module pcm_slot_dp
  import pcm_slot_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int SLOTW = 7,
  parameter int CNTW  = 11
) (
  input  logic                     bclk,
  input  logic                     rstN,
  input  ctl_t                     ctl,
  input  logic [CNTW-1:0]          effNext,
  input  logic [CNTW-1:0]          effCur,
  input  logic [NCH*SLOTW-1:0]     txSlots,
  input  logic [NCH*SLOTW-1:0]     rxSlots,
  input  logic [NCH-1:0]           wideMode,
  input  logic [NCH-1:0]           chEnable,
  input  logic [NCH*WIDE_BITS-1:0] txSamples,
  input  logic                     rxData,
  output logic                     txData,
  output logic                     txOe,
  output logic [NCH*WIDE_BITS-1:0] rxSamples,
  output logic [NCH-1:0]           rxValid
);

  localparam int SLW = CNTW - SLOT_LOG;
  localparam int SW  = WIDE_BITS;

  logic [SLW:0]          slotN, slotC;
  logic [SLOT_LOG-1:0]   bitN, bitC;
  logic [NCH-1:0]        txHit, txBit;
  logic                  anyHit, selBit;

  assign slotN = {1'b0, effNext[CNTW-1:SLOT_LOG]};
  assign bitN  = effNext[SLOT_LOG-1:0];
  assign slotC = {1'b0, effCur[CNTW-1:SLOT_LOG]};
  assign bitC  = effCur[SLOT_LOG-1:0];

  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_ch
      logic [SLW:0]        tsLo, tsHi, rsLo, rsHi;
      logic                txFirst, txSecond;
      logic                rxFirst, rxSecond, rxIn, rxDone;
      logic [SW-1:0]       src, txHold, rxShift, rxWord;
      logic [SLOT_LOG:0]   bitIdx;
      logic                validQ;

      assign tsLo = (SLW+1)'(txSlots[c*SLOTW +: SLOTW]);
      assign tsHi = tsLo + 1'b1;
      assign rsLo = (SLW+1)'(rxSlots[c*SLOTW +: SLOTW]);
      assign rsHi = rsLo + 1'b1;

      // transmit selection for the bit that starts at the coming edge
      assign txFirst  = (slotN == tsLo);
      assign txSecond = wideMode[c] & (slotN == tsHi);
      assign txHit[c] = chEnable[c] & (txFirst | txSecond);
      assign src      = ctl.frameStart ? txSamples[c*SW +: SW] : txHold;
      assign bitIdx   = {wideMode[c] & txFirst, ~bitN};
      assign txBit[c] = src[bitIdx];

      always_ff @(posedge bclk or negedge rstN) begin
        if (!rstN)               txHold <= '0;
        else if (ctl.frameStart) txHold <= txSamples[c*SW +: SW];
      end

      // receive capture in the middle of the current bit
      assign rxFirst  = (slotC == rsLo);
      assign rxSecond = wideMode[c] & (slotC == rsHi);
      assign rxIn     = ctl.rxArm & chEnable[c] & (rxFirst | rxSecond);
      assign rxDone   = rxIn & (&bitC) & (~wideMode[c] | rxSecond);

      always_ff @(negedge bclk or negedge rstN) begin
        if (!rstN) begin
          rxShift <= '0;
          rxWord  <= '0;
          validQ  <= 1'b0;
        end else begin
          validQ <= rxDone;
          if (rxIn) rxShift <= {rxShift[SW-2:0], rxData};
          if (rxDone) begin
            if (wideMode[c]) rxWord <= {rxShift[SW-2:0], rxData};
            else             rxWord <= {{SLOT_BITS{1'b0}}, rxShift[SLOT_BITS-2:0], rxData};
          end
        end
      end

      assign rxSamples[c*SW +: SW] = rxWord;
      assign rxValid[c]            = validQ;

      assert_valid_pulse_R8: assert property (@(negedge bclk) disable iff (!rstN)
        validQ |=> !validQ);

      assert_disabled_silent_R9: assert property (@(negedge bclk) disable iff (!rstN)
        validQ |-> $past(chEnable[c]));
    end
  endgenerate

  // lowest-numbered claimant wins
  always_comb begin
    anyHit = |txHit;
    selBit = 1'b0;
    for (int k = NCH - 1; k >= 0; k--) begin
      if (txHit[k]) selBit = txBit[k];
    end
  end

  always_ff @(posedge bclk or negedge rstN) begin
    if (!rstN) begin
      txOe   <= 1'b0;
      txData <= 1'b0;
    end else begin
      txOe   <= ctl.drive & anyHit;
      txData <= ctl.drive & anyHit & selBit;
    end
  end

endmodule

// File: rtl/pcm_slot_if.sv
module pcm_slot_if
  import pcm_slot_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int SLOTW = 7,
  parameter int CNTW  = 11,
  parameter int OFFW  = 3
) (
  input  logic                     bclk,
  input  logic                     rstN,
  input  logic                     fsync,
  input  logic                     rxData,
  input  logic [OFFW-1:0]          bitOffset,
  input  logic [NCH*SLOTW-1:0]     txSlots,
  input  logic [NCH*SLOTW-1:0]     rxSlots,
  input  logic [NCH-1:0]           wideMode,
  input  logic [NCH-1:0]           chEnable,
  input  logic [NCH*WIDE_BITS-1:0] txSamples,
  output logic                     txData,
  output logic                     txOe,
  output logic [NCH*WIDE_BITS-1:0] rxSamples,
  output logic [NCH-1:0]           rxValid,
  output logic [2:0]               rateCode,
  output logic                     rateLocked,
  output logic                     rateError
);

  ctl_t            ctl;
  logic [CNTW-1:0] effNext, effCur;

  pcm_slot_ctrl #(.CNTW(CNTW), .OFFW(OFFW)) u_ctrl (
    .bclk(bclk), .rstN(rstN), .fsync(fsync), .bitOffset(bitOffset),
    .ctl(ctl), .effNext(effNext), .effCur(effCur),
    .rateCode(rateCode), .rateLocked(rateLocked), .rateError(rateError)
  );

  pcm_slot_dp #(.NCH(NCH), .SLOTW(SLOTW), .CNTW(CNTW)) u_dp (
    .bclk(bclk), .rstN(rstN), .ctl(ctl), .effNext(effNext), .effCur(effCur),
    .txSlots(txSlots), .rxSlots(rxSlots), .wideMode(wideMode),
    .chEnable(chEnable), .txSamples(txSamples), .rxData(rxData),
    .txData(txData), .txOe(txOe), .rxSamples(rxSamples), .rxValid(rxValid)
  );

  assert_drive_needs_lock_R3: assert property (@(posedge bclk) disable iff (!rstN)
    txOe |-> rateLocked);

  assert_error_silent_R4: assert property (@(posedge bclk) disable iff (!rstN)
    rateError |-> !txOe);

endmodule

// File: tb/test_pcm_slot_if.sv
module test_pcm_slot_if;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;

  logic bclk = 1'b0, rstN = 1'b0, fsync = 1'b0, rxData = 1'b0;
  logic [2:0]  off = 3'd0;
  logic [27:0] txSlots, rxSlots;
  logic [3:0]  wideA = 4'b0, enA = 4'b0;
  logic [63:0] txSamples, rxSamples;
  logic txData, txOe, rateLocked, rateError;
  logic [3:0] rxValid;
  logic [2:0] rateCode;

  logic [6:0]  tsA [NCH];
  logic [6:0]  rsA [NCH];
  logic [15:0] txs [NCH];
  logic [15:0] rxv [NCH];
  logic [15:0] holdM [NCH];

  int checks = 0, fails = 0;
  bit done = 0;
  int expCh[$];
  int expVal[$];

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      txSlots[c*7 +: 7]    = tsA[c];
      rxSlots[c*7 +: 7]    = rsA[c];
      txSamples[c*16 +: 16] = txs[c];
    end
  end

  pcm_slot_if i_pcm_slot_if (
    .bclk(bclk), .rstN(rstN), .fsync(fsync), .rxData(rxData), .bitOffset(off),
    .txSlots(txSlots), .rxSlots(rxSlots), .wideMode(wideA), .chEnable(enA),
    .txSamples(txSamples), .txData(txData), .txOe(txOe), .rxSamples(rxSamples),
    .rxValid(rxValid), .rateCode(rateCode), .rateLocked(rateLocked),
    .rateError(rateError)
  );

  initial forever #(CLK_PERIOD/2) bclk = ~bclk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: pops expected receive words as strobes appear
  initial begin
    forever begin
      @(posedge bclk);
      if (rstN) begin
        for (int c = 0; c < NCH; c++) begin
          if (rxValid[c]) begin
            if (expCh.size() == 0) begin
              chk(0, "R8 or R9", "unexpected rxValid on channel", c, -1);
            end else begin
              int ec, ev;
              ec = expCh.pop_front();
              ev = expVal.pop_front();
              chk(ec == c && ev == int'(rxSamples[c*16 +: 16]), "R8",
                  "receive word", (c << 16) | int'(rxSamples[c*16 +: 16]),
                  (ec << 16) | ev);
            end
          end
        end
      end
    end
  end

  task automatic doReset();
    rstN = 1'b0;
    fsync = 1'b0;
    rxData = 1'b0;
    expCh.delete();
    expVal.delete();
    @(negedge bclk);
    chk(txOe == 0 && txData == 0 && rxValid == 0 && rateLocked == 0 && rateError == 0,
        "R1", "outputs in reset", {txOe, txData, rxValid, rateLocked, rateError}, 0);
    @(negedge bclk);
    #1 rstN = 1'b1;
  endtask

  // driver: one frame of len bits, pushing expected receive words
  task automatic runFrame(input int len, input bit expLock, input string tag,
                          input bit mutate);
    for (int i = 0; i < len; i++) begin
      int e, sl, k, w;
      bit oeE, dE, found;
      fsync = (i == 0);
      if (i == 0) for (int c = 0; c < NCH; c++) holdM[c] = txs[c];
      @(posedge bclk);
      #1;
      fsync = 1'b0;
      if (mutate && i == 4) txs[0] = 16'h005A;
      e  = (i - int'(off) + len) % len;
      sl = e / 8;
      rxData = 1'b0;
      found = 0;
      for (int c = 0; c < NCH; c++) begin
        if (!found && (sl == int'(rsA[c]) || (wideA[c] && sl == int'(rsA[c]) + 1))) begin
          found = 1;
          w = wideA[c] ? 16 : 8;
          k = (sl - int'(rsA[c])) * 8 + e % 8;
          rxData = rxv[c][w-1-k];
          if (expLock && enA[c] && k == w - 1) begin
            expCh.push_back(c);
            expVal.push_back(wideA[c] ? int'(rxv[c]) : int'(rxv[c][7:0]));
          end
        end
      end
      oeE = 0;
      dE = 0;
      found = 0;
      for (int c = 0; c < NCH; c++) begin
        if (!found && enA[c] && (sl == int'(tsA[c]) || (wideA[c] && sl == int'(tsA[c]) + 1))) begin
          found = 1;
          w = wideA[c] ? 16 : 8;
          k = (sl - int'(tsA[c])) * 8 + e % 8;
          oeE = expLock;
          dE = expLock & holdM[c][w-1-k];
        end
      end
      @(negedge bclk);
      if (oeE) chk(txOe == oeE && txData == dE, tag, "driven bit", {txOe, txData}, {oeE, dE});
      else     chk(txOe == 0 && txData == 0, "R12", "idle bit", {txOe, txData}, 0);
    end
  endtask

  task automatic baseConfig();
    off = 3'd0;
    tsA[0] = 7'd1;  rsA[0] = 7'd2;
    tsA[1] = 7'd3;  rsA[1] = 7'd5;
    tsA[2] = 7'd10; rsA[2] = 7'd10;
    tsA[3] = 7'd12; rsA[3] = 7'd14;
    wideA = 4'b0010;
    enA = 4'b0111;
    txs[0] = 16'h00A5; txs[1] = 16'hBEEF; txs[2] = 16'h003C; txs[3] = 16'h00FF;
    rxv[0] = 16'h1296; rxv[1] = 16'hC3A7; rxv[2] = 16'h0059; rxv[3] = 16'h00E1;
  endtask

  initial begin
    int lens[5];
    int codes[5];
    lens = '{193, 1024, 192, 512, 256};
    codes = '{1, 4, 0, 3, 2};
    baseConfig();

    // main slot map, offset 0
    doReset();
    runFrame(256, 0, "R3", 0);
    runFrame(256, 0, "R3", 0);
    chk(rateLocked == 0, "R3", "not locked after one measurement", rateLocked, 0);
    runFrame(256, 1, "R2/R5/R6", 0);
    chk(rateLocked == 1 && rateCode == 3'd2, "R3", "lock at 256", {rateLocked, rateCode}, 4'hA);
    runFrame(256, 1, "R11", 1);
    runFrame(256, 1, "R11", 0);
    chk(expCh.size() == 0, "R8", "all receive words seen", expCh.size(), 0);

    // offset
    doReset();
    off = 3'd3;
    enA = 4'b1111;
    txs[0] = 16'h00C3;
    for (int f = 0; f < 4; f++) runFrame(256, f >= 2, "R7", 0);
    chk(expCh.size() == 0, "R7", "offset receive words seen", expCh.size(), 0);

    // overlap priority
    doReset();
    off = 3'd0;
    tsA[2] = 7'd1;
    txs[2] = 16'h005A;
    for (int f = 0; f < 4; f++) runFrame(256, f >= 2, "R10", 0);
    chk(expCh.size() == 0, "R10", "overlap receive words seen", expCh.size(), 0);

    // rate sweep with all channels off
    baseConfig();
    enA = 4'b0000;
    doReset();
    for (int n = 0; n < 5; n++) begin
      runFrame(lens[n], 0, "R9", 0);
      runFrame(lens[n], 0, "R9", 0);
      chk(rateLocked == 0, "R4", "lock dropped on new length", rateLocked, 0);
      runFrame(lens[n], 0, "R9", 0);
      chk(rateLocked == 1 && rateCode == 3'(codes[n]) && rateError == 0, "R3",
          "rate code", {rateError, rateLocked, rateCode}, 8 | codes[n]);
    end

    // error paths
    baseConfig();
    doReset();
    runFrame(256, 0, "R3", 0);
    runFrame(256, 0, "R3", 0);
    runFrame(256, 1, "R5", 0);
    runFrame(300, 1, "R5", 0);
    runFrame(256, 0, "R4", 0);
    chk(rateError == 1 && rateLocked == 0, "R4", "unsupported length",
        {rateError, rateLocked}, 2);
    runFrame(256, 0, "R4", 0);
    chk(rateError == 0 && rateLocked == 0, "R4", "recovery measurement",
        {rateError, rateLocked}, 0);
    runFrame(256, 1, "R5", 0);
    chk(rateLocked == 1, "R3", "relock", rateLocked, 1);
    for (int i = 0; i < 2100; i++) begin
      @(negedge bclk);
      if (txOe !== 1'b0) chk(0, "R4", "drive while starved", txOe, 0);
    end
    chk(rateError == 1 && rateLocked == 0 && txOe == 0, "R4", "missing frame sync",
        {rateError, rateLocked, txOe}, 4);
    chk(expCh.size() == 0, "R8", "error phase receive words seen", expCh.size(), 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule